// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block chooses which interrupt a small 8-bit CPU core services next. There are up to 22 numbered sources. Each source supplies a pending flag, an enable bit and a priority bit. A master enable gates all of them. Every clock cycle the block samples the eligible requests and registers a winner. The winner may be taken at an instruction boundary. After that, the block drives a four-cycle call request carrying the source number and its vector address. On the last call cycle it pulses a one-hot acknowledge, which clears edge-type flags.

Two service levels are tracked, low and high. A high request may interrupt a running low routine. Nothing interrupts a high routine. A request at the same level or a lower level waits for a return. After a return, one more instruction must retire before the next call can start. A stall input blocks every take, for example during a nonvolatile write. Requests stay pending at the source until the stall ends.

Top module: `nested_irq_ctrl`

## Requirements
- R1: During and right after reset, `req_o` is 0, `ack_o` is all zeros and `in_svc_o` is 2'b00.
- R2: A source is eligible only when its pending bit, its enable bit and `gie_i` are all 1. Source slot 20 has nothing attached and never wins, even when pending and enabled.
- R3: Among eligible sources, any source whose `prio_i` bit is 1 (high) beats every source whose bit is 0 (low). Within one level, the lowest source number wins.
- R4: While `req_o` is 1, `req_vec_o` equals 0x0003 + 8 × `req_id_o`. For example, source 15 gives 0x007B and source 21 gives 0x00AB.
- R5: Detection takes one cycle. The call then keeps `req_o` high for 4 cycles, and `ack_o` pulses with bit `req_id_o` set on the 4th of those cycles. With `insn_done_i` held high and no blocking, `ack_o` appears 5 clock edges after a pending bit rises. `in_svc_o` bit 0 (low) or bit 1 (high) sets for the granted level at the next edge.
- R6: A high request is taken when only the low level is in service (`in_svc_o` = 2'b01), which gives nesting to 2'b11.
- R7: A low request waits while any level is in service. No request is taken while the high level is in service.
- R8: A `reti_i` strobe clears `in_svc_o` bit 1 if it is set, and otherwise clears bit 0.
- R9: A take happens only on a cycle with `insn_done_i` = 1 and `reti_i` = 0. After a return, the next instruction boundary is therefore the earliest point at which a call can start.
- R10: While `stall_i` is 1, no call starts. The pending winner is taken at the first boundary after `stall_i` falls, with `ack_o` 4 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pend_i | input | 22 | Per-source pending flags |
| en_i | input | 22 | Per-source enable bits |
| prio_i | input | 22 | Per-source priority (1 = high) |
| gie_i | input | 1 | Master interrupt enable |
| insn_done_i | input | 1 | Instruction boundary strobe |
| reti_i | input | 1 | Return-from-interrupt strobe (on a boundary) |
| stall_i | input | 1 | Blocks taking interrupts |
| req_o | output | 1 | Call sequence in progress |
| req_hi_o | output | 1 | Level of the request being called |
| req_id_o | output | 5 | Source number being called |
| req_vec_o | output | 16 | Vector address of that source |
| ack_o | output | 22 | One-hot acknowledge, last call cycle |
| in_svc_o | output | 2 | In-service levels: bit 1 high, bit 0 low |

## Verification
The hardest state to reach is full nesting. A low routine must be in service, a high routine must preempt it, and further high and low requests must wait behind both. Return strobes must then unwind the levels in the right order. The stimulus gets there in steps: it raises one low source, then a high source while that low source is in service, then a second high source. It issues returns one at a time and checks which level clears. It also withholds instruction boundaries after a return, to show that the post-return boundary, and not the return itself, starts the next call.

// File: rtl/irq_ctrl_pkg.sv
`timescale 1ns/1ps
package irq_ctrl_pkg;
  typedef enum logic {
    CS_IDLE = 1'b0,
    CS_CALL = 1'b1
  } call_state_e;

  localparam int unsigned LVL_LO = 0;
  localparam int unsigned LVL_HI = 1;
endpackage

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter #(
  parameter int unsigned N_SRC       = 22,
  parameter int unsigned ID_W        = 5,
  parameter int unsigned UNUSED_SLOT = 20
) (
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] prio_i,
  input  logic             gie_i,
  output logic             win_valid_o,
  output logic             win_hi_o,
  output logic [ID_W-1:0]  win_id_o
);
  import irq_ctrl_pkg::*;

  localparam logic [N_SRC-1:0] UNUSED_MASK = N_SRC'(1) << UNUSED_SLOT;

  logic [N_SRC-1:0]         elig;
  logic [1:0]               lvl_hit;
  logic [1:0][ID_W-1:0]     lvl_id;

  assign elig = pend_i & en_i & {N_SRC{gie_i}} & ~UNUSED_MASK;

  // one fixed-order encoder per level
  for (genvar l = 0; l < 2; l++) begin : g_lvl
    logic [N_SRC-1:0] grp;
    logic             hit_l;
    logic [ID_W-1:0]  id_l;

    assign grp = elig & ((l == LVL_HI) ? prio_i : ~prio_i);

    always_comb begin
      hit_l = |grp;
      id_l  = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
        if (grp[i]) id_l = ID_W'(i);
      end
    end

    assign lvl_hit[l] = hit_l;
    assign lvl_id[l]  = id_l;
  end

  assign win_valid_o = |lvl_hit;
  assign win_hi_o    = lvl_hit[LVL_HI];
  assign win_id_o    = lvl_hit[LVL_HI] ? lvl_id[LVL_HI] : lvl_id[LVL_LO];

  // R2: the winner is an eligible, attached source
  always_comb begin
    if (win_valid_o) begin
      a_r2_win_eligible: assert (elig[win_id_o] && (win_id_o != ID_W'(UNUSED_SLOT)));
    end
  end
endmodule

// File: rtl/irq_svc_tracker.sv
`timescale 1ns/1ps
module irq_svc_tracker (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_i,
  input  logic       set_hi_i,
  input  logic       ret_i,
  output logic [1:0] in_svc_o
);
  import irq_ctrl_pkg::*;

  logic [1:0] svc_q, svc_d;

  always_comb begin
    svc_d = svc_q;
    if (ret_i) begin
      if (svc_d[LVL_HI]) svc_d[LVL_HI] = 1'b0;
      else               svc_d[LVL_LO] = 1'b0;
    end
    if (set_i) begin
      if (set_hi_i) svc_d[LVL_HI] = 1'b1;
      else          svc_d[LVL_LO] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) svc_q <= '0;
    else         svc_q <= svc_d;
  end

  assign in_svc_o = svc_q;

  a_r8_ret_hi_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !set_i && svc_q[1]) |=> (svc_q == {1'b0, $past(svc_q[0])}));

  a_r8_ret_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !set_i && svc_q == 2'b01) |=> (svc_q == 2'b00));

  a_r5_hi_set_by_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(svc_q[1]) |-> ($past(set_i) && $past(set_hi_i)));
endmodule

// File: rtl/irq_call_seq.sv
`timescale 1ns/1ps
module irq_call_seq #(
  parameter int unsigned ID_W     = 5,
  parameter int unsigned CALL_CYC = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cand_valid_i,
  input  logic            cand_hi_i,
  input  logic [ID_W-1:0] cand_id_i,
  input  logic [1:0]      in_svc_i,
  input  logic            insn_done_i,
  input  logic            reti_i,
  input  logic            stall_i,
  output logic            req_o,
  output logic            req_hi_o,
  output logic [ID_W-1:0] req_id_o,
  output logic            grant_o
);
  import irq_ctrl_pkg::*;

  localparam int unsigned CNT_W = (CALL_CYC > 1) ? $clog2(CALL_CYC) : 1;

  call_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hi_q;
  logic [ID_W-1:0]  id_q;
  logic             allow, take, last;

  // high may nest over low only; low needs an idle core
  assign allow = cand_hi_i ? !in_svc_i[LVL_HI] : (in_svc_i == 2'b00);
  assign take  = (state_q == CS_IDLE) && cand_valid_i && allow &&
                 insn_done_i && !reti_i && !stall_i;
  assign last  = (state_q == CS_CALL) && (cnt_q == CNT_W'(CALL_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CS_IDLE;
      cnt_q   <= '0;
      hi_q    <= 1'b0;
      id_q    <= '0;
    end else if (take) begin
      state_q <= CS_CALL;
      cnt_q   <= '0;
      hi_q    <= cand_hi_i;
      id_q    <= cand_id_i;
    end else if (last) begin
      state_q <= CS_IDLE;
    end else if (state_q == CS_CALL) begin
      cnt_q   <= cnt_q + CNT_W'(1);
    end
  end

  assign req_o    = (state_q == CS_CALL);
  assign req_hi_o = hi_q;
  assign req_id_o = id_q;
  assign grant_o  = last;

  a_r7_no_take_over_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> !$past(in_svc_i[1]));

  a_r7_lo_needs_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(req_o) && !req_hi_o) |-> ($past(in_svc_i) == 2'b00));

  a_r9_take_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> ($past(insn_done_i) && !$past(reti_i)));

  a_r10_no_take_in_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> !$past(stall_i));

  a_r5_gap_after_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |=> !req_o);

  a_r5_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !grant_o) |=> (req_o && $stable(req_id_o)));
endmodule

// File: rtl/nested_irq_ctrl.sv
`timescale 1ns/1ps
module nested_irq_ctrl #(
  parameter int unsigned N_SRC       = 22,
  parameter int unsigned UNUSED_SLOT = 20,
  parameter int unsigned CALL_CYC    = 4,
  parameter int unsigned VEC_W       = 16,
  parameter int unsigned VEC_BASE    = 3,
  parameter int unsigned VEC_STEP    = 8,
  localparam int unsigned ID_W       = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] prio_i,
  input  logic             gie_i,
  input  logic             insn_done_i,
  input  logic             reti_i,
  input  logic             stall_i,
  output logic             req_o,
  output logic             req_hi_o,
  output logic [ID_W-1:0]  req_id_o,
  output logic [VEC_W-1:0] req_vec_o,
  output logic [N_SRC-1:0] ack_o,
  output logic [1:0]       in_svc_o
);
  logic            win_valid, win_hi;
  logic [ID_W-1:0] win_id;
  logic            cand_valid_q, cand_hi_q;
  logic [ID_W-1:0] cand_id_q;
  logic            grant;

  irq_arbiter #(
    .N_SRC      (N_SRC),
    .ID_W       (ID_W),
    .UNUSED_SLOT(UNUSED_SLOT)
  ) i_arb (
    .pend_i     (pend_i),
    .en_i       (en_i),
    .prio_i     (prio_i),
    .gie_i      (gie_i),
    .win_valid_o(win_valid),
    .win_hi_o   (win_hi),
    .win_id_o   (win_id)
  );

  // detection stage: winner sampled every cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_valid_q <= 1'b0;
      cand_hi_q    <= 1'b0;
      cand_id_q    <= '0;
    end else begin
      cand_valid_q <= win_valid;
      cand_hi_q    <= win_hi;
      cand_id_q    <= win_id;
    end
  end

  irq_call_seq #(
    .ID_W    (ID_W),
    .CALL_CYC(CALL_CYC)
  ) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cand_valid_i(cand_valid_q),
    .cand_hi_i   (cand_hi_q),
    .cand_id_i   (cand_id_q),
    .in_svc_i    (in_svc_o),
    .insn_done_i (insn_done_i),
    .reti_i      (reti_i),
    .stall_i     (stall_i),
    .req_o       (req_o),
    .req_hi_o    (req_hi_o),
    .req_id_o    (req_id_o),
    .grant_o     (grant)
  );

  irq_svc_tracker i_svc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (grant),
    .set_hi_i(req_hi_o),
    .ret_i   (reti_i),
    .in_svc_o(in_svc_o)
  );

  assign req_vec_o = VEC_W'(VEC_BASE) + VEC_W'(VEC_STEP) * VEC_W'(req_id_o);
  assign ack_o     = grant ? (N_SRC'(1) << req_id_o) : '0;

  a_r5_ack_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o));

  a_r2_no_unused_call: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (req_id_o != ID_W'(UNUSED_SLOT)));

  a_r5_ack_inside_call: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o != '0) |-> req_o);
endmodule

// File: tb/test_nested_irq_ctrl.sv
`timescale 1ns/1ps
module test_nested_irq_ctrl;
  localparam int N = 22;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pend = '0, en = '1, prio = '0;
  logic          gie = 1'b1, insn = 1'b1, reti = 1'b0, stall = 1'b0;
  logic          req, req_hi;
  logic [4:0]    req_id;
  logic [15:0]   req_vec;
  logic [N-1:0]  ack;
  logic [1:0]    in_svc;

  int checks = 0;
  int errors = 0;
  int exp_q[$];

  always #2 clk = ~clk;

  nested_irq_ctrl i_nested_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .pend_i(pend), .en_i(en), .prio_i(prio),
    .gie_i(gie), .insn_done_i(insn), .reti_i(reti), .stall_i(stall),
    .req_o(req), .req_hi_o(req_hi), .req_id_o(req_id), .req_vec_o(req_vec),
    .ack_o(ack), .in_svc_o(in_svc)
  );

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req_tag, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // edges until ack is seen, sampled just after each edge
  task automatic wait_ack(output int n);
    n = 0;
    do begin
      step(1);
      n++;
    end while (ack == '0 && n < 30);
  endtask

  task automatic expect_none(input int n, input string req_tag);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (req) seen = 1;
    end
    chk(!seen, req_tag, int'(seen), 0);
  endtask

  task automatic do_reti();
    reti = 1'b1;
    step(1);
    reti = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    int e;
    if (rst_n && ack != '0) begin
      if (exp_q.size() == 0) begin
        chk(0, "R3 unexpected grant", int'(req_id), -1);
      end else begin
        e = exp_q.pop_front();
        chk(int'(req_id) == e, "R3 grant order", int'(req_id), e);
      end
      chk(ack == (N'(1) << req_id), "R5 ack one-hot", int'(ack), 1 << req_id);
      chk(req_vec == 16'(3 + 8 * int'(req_id)), "R4 vector", int'(req_vec), 3 + 8 * int'(req_id));
      pend[req_id] = 1'b0;
    end
  end

  initial begin
    #400000;
    chk(0, "watchdog", 0, 1);
    finish_sim();
  end

  initial begin
    int n;
    step(2);
    chk(req == 1'b0 && ack == '0 && in_svc == 2'b00, "R1 reset state",
        int'({req, in_svc}), 0);
    rst_n = 1'b1;
    step(1);
    chk(req == 1'b0 && in_svc == 2'b00, "R1 after reset", int'({req, in_svc}), 0);

    // R5 minimum latency
    exp_q.push_back(5);
    pend[5] = 1'b1;
    wait_ack(n);
    chk(n == 5, "R5 latency", n, 5);
    step(1);
    chk(in_svc == 2'b01, "R5 low in service", int'(in_svc), 1);
    do_reti();
    chk(in_svc == 2'b00, "R8 return clears low", int'(in_svc), 0);

    // R3 arbitration: high 7 beats low 2,3; then lowest low
    prio[7] = 1'b1;
    exp_q.push_back(7);
    exp_q.push_back(2);
    pend[3] = 1'b1; pend[7] = 1'b1; pend[2] = 1'b1;
    wait_ack(n);
    step(1);
    chk(in_svc == 2'b10, "R3 high first", int'(in_svc), 2);
    expect_none(10, "R7 low waits under high");
    do_reti();
    chk(in_svc == 2'b00, "R8 return clears high", int'(in_svc), 0);
    wait_ack(n);
    step(1);
    chk(in_svc == 2'b01, "R3 lowest low next", int'(in_svc), 1);
    expect_none(8, "R7 equal level blocked");

    // R6 preemption of low by high
    prio[9] = 1'b1;
    exp_q.push_back(9);
    pend[9] = 1'b1;
    wait_ack(n);
    chk(n == 5, "R6 preempt latency", n, 5);
    step(1);
    chk(in_svc == 2'b11, "R6 nested", int'(in_svc), 3);
    prio[1] = 1'b1;
    pend[1] = 1'b1;
    expect_none(8, "R7 nothing preempts high");
    exp_q.push_back(1);
    do_reti();
    chk(in_svc == 2'b01, "R8 high cleared first", int'(in_svc), 1);
    wait_ack(n);
    step(1);
    chk(in_svc == 2'b11, "R6 high again over low", int'(in_svc), 3);
    do_reti();
    chk(in_svc == 2'b01, "R8 unwind high", int'(in_svc), 1);

    // R9 post-return boundary
    exp_q.push_back(3);
    reti = 1'b1;
    step(1);
    reti = 1'b0;
    insn = 1'b0;
    chk(in_svc == 2'b00, "R8 unwind low", int'(in_svc), 0);
    expect_none(6, "R9 no boundary no take");
    insn = 1'b1;
    step(1);
    insn = 1'b0;
    chk(req == 1'b1, "R9 take at first boundary", int'(req), 1);
    insn = 1'b1;
    wait_ack(n);
    step(1);
    do_reti();

    // R10 stall
    stall = 1'b1;
    exp_q.push_back(6);
    pend[6] = 1'b1;
    expect_none(8, "R10 stall blocks");
    stall = 1'b0;
    wait_ack(n);
    chk(n == 4, "R10 take after stall", n, 4);
    step(1);
    do_reti();

    // R2 eligibility
    pend[20] = 1'b1;
    expect_none(8, "R2 unused slot");
    pend[20] = 1'b0;
    gie = 1'b0;
    pend[0] = 1'b1;
    expect_none(6, "R2 master enable");
    en[0] = 1'b0;
    gie = 1'b1;
    expect_none(6, "R2 source enable");
    exp_q.push_back(0);
    en[0] = 1'b1;
    wait_ack(n);
    chk(n == 5, "R2 enabled source taken", n, 5);
    step(1);
    do_reti();

    // R4 vectors at the top of the range
    prio[21] = 1'b1;
    exp_q.push_back(21);
    pend[21] = 1'b1;
    wait_ack(n);
    chk(req_vec == 16'h00AB, "R4 vector 21", int'(req_vec), 16'h00AB);
    step(1);
    do_reti();
    exp_q.push_back(15);
    pend[15] = 1'b1;
    wait_ack(n);
    chk(req_vec == 16'h007B, "R4 vector 15", int'(req_vec), 16'h007B);
    step(1);
    do_reti();

    step(4);
    chk(exp_q.size() == 0, "R3 all grants seen", exp_q.size(), 0);
    finish_sim();
  end
endmodule